// File: doc/BRIEF.md
# Word Parity Guard with Three-Mode Control

This block protects a memory organised as 256-bit words. A small side array holds one parity bit and one valid bit for each word. Full-width aligned writes refresh the parity, and qualifying reads compare it with the XOR of the returned data. Two read requesters share the checker: instruction fetch and DMA. Each has its own error pulse output. A command port with write-one semantics moves the checker between enabled, disabled and suspended operation and clears recorded errors. A status word and a captured error address report what happened.

The suspended mode supports fault injection. Software fills words while enabled, suspends the checker, overwrites data without touching the side array, then re-enables and reads the word back to confirm that the checker flags it. Only one error is held at a time. A fetch error is the only event that may replace a held DMA error.

A read and a write issued in the same cycle see the side array as it was before that cycle's write. The word index is taken from address bits just above the 5-bit byte offset.

Top module: `pchk_ctrl`

## Requirements
- R1: After reset the checker is in disabled mode (status = 5'b00010), no error flag is set, both pulses are low and the captured address is zero.
- R2: A command write with exactly one of bit0 (enable), bit1 (disable), bit2 (suspend) set selects that mode on the next cycle. A command write with none of them set leaves the mode unchanged. A command write with more than one of them set selects disabled. Status bits 0/1/2 show enabled/disabled/suspended, and exactly one of them is 1.
- R3: When enabled, a write with `wr_full`=1 and address bits [4:0]=0 stores the XOR of the 256 data bits and marks the word valid. A later checked read whose data XOR differs from the stored parity reports an error.
- R4: When enabled, a write that is narrow or misaligned marks the word invalid. A later read of that word reports no error, whatever its data.
- R5: When disabled, every write marks its word invalid and no read is checked.
- R6: When suspended, writes leave parity and valid unchanged and no read is checked. A word filled while enabled and corrupted while suspended is flagged once the checker is enabled again.
- R7: A read is checked only if it is full-width, has address bits [4:0]=0 and has `rd_dbg`=0. Debug, narrow or misaligned reads never report.
- R8: An error is recorded only when no flag is held. Recording sets status bit3 (`rd_src`=0, fetch) or bit4 (`rd_src`=1, DMA), never both. Later errors produce no pulse and change nothing until the flag is cleared.
- R9: A fetch error arriving while a DMA error is held clears bit4, sets bit3, replaces the captured address and pulses `fetch_err`.
- R10: The captured address holds read-address bits [31:5], and `err_ram` holds the read's region bit (1 = RAM, 0 = cache). Both keep their value until the next recorded error.
- R11: Command bit3 clears the fetch flag and bit4 clears the DMA flag. They may be combined with each other and with one mode bit. A clear takes effect before an error detected in the same cycle, so that error is recorded.
- R12: `fetch_err` and `dma_err` are one-cycle pulses issued in the cycle after the failing read, one for each recorded error, on the output that matches its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write to the guarded memory this cycle |
| wr_addr | input | 32 | Byte address of the write |
| wr_full | input | 1 | Write covers all 256 bits |
| wr_data | input | 256 | Write data |
| rd_en | input | 1 | Read from the guarded memory this cycle, data valid |
| rd_src | input | 1 | Requester: 0 fetch, 1 DMA |
| rd_addr | input | 32 | Byte address of the read |
| rd_full | input | 1 | Read covers all 256 bits |
| rd_dbg | input | 1 | Debug access, never checked |
| rd_ram | input | 1 | Read hit RAM region (1) or cache region (0) |
| rd_data | input | 256 | Data returned by the memory |
| cmd_we | input | 1 | Command write strobe |
| cmd_bits | input | 5 | Write-one command bits (see R2, R11) |
| stat | output | 5 | Mode bits [2:0], fetch flag [3], DMA flag [4] |
| err_addr | output | 27 | Captured read-address bits [31:5] |
| err_ram | output | 1 | Region of captured error |
| fetch_err | output | 1 | Fetch parity error pulse |
| dma_err | output | 1 | DMA parity error pulse |

## Verification
The bench targets the fetch-over-DMA replacement. A design that records only the first error would keep the DMA address and never pulse `fetch_err`. A design that replaces in both directions would let a DMA error overwrite a held fetch error. The bench also runs the suspend-and-corrupt sequence. A design that invalidates words while suspended would miss the injected fault, and one that checks while suspended would report too early. It also issues multi-bit mode commands, which must land in disabled rather than in the lowest selected mode, and a clear in the same cycle as a fresh error, which must be recorded rather than lost.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
    typedef enum logic [1:0] {
        MODE_ON   = 2'd0,
        MODE_OFF  = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;

    localparam int CMD_W   = 5;
    localparam int CB_ON   = 0;
    localparam int CB_OFF  = 1;
    localparam int CB_HOLD = 2;
    localparam int CB_CLRF = 3;
    localparam int CB_CLRD = 4;
endpackage

// File: rtl/pchk_mode.sv
module pchk_mode
    import pchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [2:0] cmd_mode,
    output mode_e      mode
);
    typedef struct packed {
        mode_e cur;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic [1:0] n_set;

    always_comb begin
        st_d  = st_q;
        n_set = 2'(cmd_mode[0]) + 2'(cmd_mode[1]) + 2'(cmd_mode[2]);
        if (cmd_we) begin
            if (n_set > 2'd1)       st_d.cur = MODE_OFF;
            else if (cmd_mode[CB_ON])   st_d.cur = MODE_ON;
            else if (cmd_mode[CB_OFF])  st_d.cur = MODE_OFF;
            else if (cmd_mode[CB_HOLD]) st_d.cur = MODE_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cur: MODE_OFF};
        else        st_q <= st_d;
    end

    assign mode = st_q.cur;
endmodule

// File: rtl/pchk_side.sv
module pchk_side
    import pchk_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 32,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_full,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_full,
    input  logic              rd_dbg,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_bad
);
    localparam int OFFS_W = $clog2(DATA_W / 8);
    localparam int IDX_W  = $clog2(WORDS);

    typedef struct packed {
        logic [WORDS-1:0] par;
        logic [WORDS-1:0] vld;
    } side_st_t;

    side_st_t st_d, st_q;
    logic [IDX_W-1:0] widx, ridx;
    logic             wr_whole, rd_whole;

    assign widx     = wr_addr[OFFS_W +: IDX_W];
    assign ridx     = rd_addr[OFFS_W +: IDX_W];
    assign wr_whole = wr_full && (wr_addr[OFFS_W-1:0] == '0);
    assign rd_whole = rd_full && (rd_addr[OFFS_W-1:0] == '0) && !rd_dbg;

    always_comb begin
        st_d = st_q;
        if (wr_en && mode != MODE_HOLD) begin
            if (mode == MODE_ON && wr_whole) begin
                st_d.par[widx] = ^wr_data;
                st_d.vld[widx] = 1'b1;
            end else begin
                st_d.vld[widx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_bad = rd_en && (mode == MODE_ON) && rd_whole &&
                    st_q.vld[ridx] && ((^rd_data) != st_q.par[ridx]);
endmodule

// File: rtl/pchk_log.sv
module pchk_log #(
    parameter int TAG_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bad,
    input  logic             src,
    input  logic [TAG_W-1:0] tag,
    input  logic             ram,
    input  logic             clr_f,
    input  logic             clr_d,
    output logic             flag_f,
    output logic             flag_d,
    output logic [TAG_W-1:0] tag_q,
    output logic             ram_q,
    output logic             pulse_f,
    output logic             pulse_d
);
    typedef struct packed {
        logic             ff;
        logic             fd;
        logic [TAG_W-1:0] tag;
        logic             ram;
        logic             pf;
        logic             pd;
    } log_st_t;

    log_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ff = st_q.ff && !clr_f;
        st_d.fd = st_q.fd && !clr_d;
        st_d.pf = 1'b0;
        st_d.pd = 1'b0;
        if (bad && !src && !st_d.ff) begin
            st_d.ff  = 1'b1;
            st_d.fd  = 1'b0;
            st_d.tag = tag;
            st_d.ram = ram;
            st_d.pf  = 1'b1;
        end else if (bad && src && !st_d.ff && !st_d.fd) begin
            st_d.fd  = 1'b1;
            st_d.tag = tag;
            st_d.ram = ram;
            st_d.pd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_f  = st_q.ff;
    assign flag_d  = st_q.fd;
    assign tag_q   = st_q.tag;
    assign ram_q   = st_q.ram;
    assign pulse_f = st_q.pf;
    assign pulse_d = st_q.pd;
endmodule

// File: rtl/pchk_ctrl.sv
module pchk_ctrl
    import pchk_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 32,
    parameter int WORDS  = 16,
    localparam int OFFS_W = $clog2(DATA_W / 8),
    localparam int TAG_W  = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_full,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_src,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_full,
    input  logic              rd_dbg,
    input  logic              rd_ram,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_bits,
    output logic [CMD_W-1:0]  stat,
    output logic [TAG_W-1:0]  err_addr,
    output logic              err_ram,
    output logic              fetch_err,
    output logic              dma_err
);
    mode_e mode;
    logic  rd_bad, flag_f, flag_d;

    pchk_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_mode (cmd_bits[CB_HOLD:CB_ON]),
        .mode     (mode)
    );

    pchk_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_side (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_full (wr_full),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_full (rd_full),
        .rd_dbg  (rd_dbg),
        .rd_data (rd_data),
        .rd_bad  (rd_bad)
    );

    pchk_log #(.TAG_W(TAG_W)) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .bad     (rd_bad),
        .src     (rd_src),
        .tag     (rd_addr[ADDR_W-1:OFFS_W]),
        .ram     (rd_ram),
        .clr_f   (cmd_we && cmd_bits[CB_CLRF]),
        .clr_d   (cmd_we && cmd_bits[CB_CLRD]),
        .flag_f  (flag_f),
        .flag_d  (flag_d),
        .tag_q   (err_addr),
        .ram_q   (err_ram),
        .pulse_f (fetch_err),
        .pulse_d (dma_err)
    );

    assign stat = {flag_d, flag_f, mode == MODE_HOLD, mode == MODE_OFF, mode == MODE_ON};
endmodule

// File: rtl/pchk_ctrl_chk.sv
module pchk_ctrl_chk #(
    parameter int TAG_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             rd_dbg,
    input logic [4:0]       stat,
    input logic [TAG_W-1:0] err_addr,
    input logic             err_ram,
    input logic             fetch_err,
    input logic             dma_err
);
    // R2
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat[2:0]) == 1);

    // R8
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat[3] && stat[4]));

    // R12
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> stat[3] && !dma_err);

    // R12
    dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_err |-> stat[4] && !stat[3]);

    // R5
    quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !stat[0]) |=> !(fetch_err || dma_err));

    // R7
    dbg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_dbg) |=> !(fetch_err || dma_err));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(err_addr) && $stable(err_ram));
endmodule

bind pchk_ctrl pchk_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_dbg    (rd_dbg),
    .stat      (stat),
    .err_addr  (err_addr),
    .err_ram   (err_ram),
    .fetch_err (fetch_err),
    .dma_err   (dma_err)
);

// File: tb/pchk_ctrl_test.sv
`timescale 1ns/1ps
module pchk_ctrl_test;
    localparam int WORDS = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 0, wr_full = 0;
    logic [31:0]  wr_addr = 0;
    logic [255:0] wr_data = 0;
    logic         rd_en = 0, rd_src = 0, rd_full = 0, rd_dbg = 0, rd_ram = 0;
    logic [31:0]  rd_addr = 0;
    logic [255:0] rd_data = 0;
    logic         cmd_we = 0;
    logic [4:0]   cmd_bits = 0;
    logic [4:0]   stat;
    logic [26:0]  err_addr;
    logic         err_ram, fetch_err, dma_err;

    always #2.5 clk = ~clk;

    pchk_ctrl uut (.*);

    // reference state
    int           m_mode;          // 0 on, 1 off, 2 hold
    bit           m_par [WORDS];
    bit           m_vld [WORDS];
    bit           m_ff, m_fd, m_ram, m_pf, m_pd;
    bit [26:0]    m_addr;
    int           checks = 0, fails = 0;
    string        tag = "R1";
    bit           done = 0;

    task automatic model_reset();
        m_mode = 1;
        for (int i = 0; i < WORDS; i++) begin m_par[i] = 0; m_vld[i] = 0; end
        m_ff = 0; m_fd = 0; m_ram = 0; m_pf = 0; m_pd = 0; m_addr = 0;
    endtask

    task automatic model_step();
        int  ri, wi, n;
        bit  hit, ff, fd;
        ri  = int'(rd_addr[8:5]);
        wi  = int'(wr_addr[8:5]);
        hit = rd_en && m_mode == 0 && rd_full && rd_addr[4:0] == 0 && !rd_dbg &&
              m_vld[ri] && ((^rd_data) != m_par[ri]);
        if (wr_en) begin
            if (m_mode == 0) begin
                if (wr_full && wr_addr[4:0] == 0) begin
                    m_par[wi] = ^wr_data; m_vld[wi] = 1;
                end else m_vld[wi] = 0;
            end else if (m_mode == 1) m_vld[wi] = 0;
        end
        if (cmd_we) begin
            n = int'(cmd_bits[0]) + int'(cmd_bits[1]) + int'(cmd_bits[2]);
            if (n > 1) m_mode = 1;
            else if (cmd_bits[0]) m_mode = 0;
            else if (cmd_bits[1]) m_mode = 1;
            else if (cmd_bits[2]) m_mode = 2;
        end
        ff = m_ff && !(cmd_we && cmd_bits[3]);
        fd = m_fd && !(cmd_we && cmd_bits[4]);
        m_pf = 0; m_pd = 0;
        if (hit && rd_src == 0 && !ff) begin
            ff = 1; fd = 0; m_addr = rd_addr[31:5]; m_ram = rd_ram; m_pf = 1;
        end else if (hit && rd_src == 1 && !ff && !fd) begin
            fd = 1; m_addr = rd_addr[31:5]; m_ram = rd_ram; m_pd = 1;
        end
        m_ff = ff; m_fd = fd;
    endtask

    task automatic compare();
        bit [4:0] es;
        es = {m_fd, m_ff, m_mode == 2, m_mode == 1, m_mode == 0};
        checks++;
        if (stat !== es || err_addr !== m_addr || err_ram !== m_ram ||
            fetch_err !== m_pf || dma_err !== m_pd) begin
            fails++;
            $display("FAIL %s: got stat=%b addr=%h ram=%b fe=%b de=%b exp stat=%b addr=%h ram=%b fe=%b de=%b",
                     tag, stat, err_addr, err_ram, fetch_err, dma_err,
                     es, m_addr, m_ram, m_pf, m_pd);
        end
    endtask

    task automatic expect1(string t, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b exp %b", t, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        wr_en = 0; wr_full = 0; rd_en = 0; rd_full = 0; rd_dbg = 0;
        cmd_we = 0; cmd_bits = 0;
    endtask

    function automatic logic [255:0] rnd();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic wr(logic [31:0] a, logic [255:0] d, logic full);
        wr_en = 1; wr_addr = a; wr_data = d; wr_full = full; cyc();
    endtask

    task automatic rd(logic src, logic [31:0] a, logic [255:0] d, logic full, logic dbg, logic ram);
        rd_en = 1; rd_src = src; rd_addr = a; rd_data = d; rd_full = full;
        rd_dbg = dbg; rd_ram = ram; cyc();
    endtask

    task automatic cmd(logic [4:0] b);
        cmd_we = 1; cmd_bits = b; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [255:0] dA, dB, dC;
        dA = rnd(); dB = rnd(); dC = rnd();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; compare();

        tag = "R2";
        cmd(5'b00001);                  // enable
        cmd(5'b00000);                  // no change
        cmd(5'b00101);                  // two mode bits -> disabled
        expect1("R2 multi-bit disables", stat[1], 1'b1);
        cmd(5'b00100);                  // suspend
        cmd(5'b00111);                  // all three -> disabled
        cmd(5'b00001);

        tag = "R3";
        wr(32'h0000_0100, dA, 1);
        wr(32'h8000_01E0, dC, 1);
        rd(0, 32'h0000_0100, dA, 1, 0, 1);
        rd(0, 32'h0000_0100, dA ^ 256'h1, 1, 0, 1);
        expect1("R12 fetch pulse", fetch_err, 1'b1);
        tag = "R10"; cyc();
        tag = "R8";
        rd(1, 32'h8000_01E0, dC ^ 256'h2, 1, 0, 0);
        rd(0, 32'h8000_01E0, dC ^ 256'h2, 1, 0, 0);
        expect1("R8 suppressed", fetch_err, 1'b0);
        tag = "R11"; cmd(5'b01000);
        tag = "R9";
        rd(1, 32'h8000_01E0, dC ^ 256'h4, 1, 0, 0);
        expect1("R12 dma pulse", dma_err, 1'b1);
        rd(1, 32'h0000_0100, dA ^ 256'h4, 1, 0, 1);
        rd(0, 32'h0000_0100, dA ^ 256'h8, 1, 0, 1);
        expect1("R9 override", stat[3] && !stat[4], 1'b1);
        rd(1, 32'h8000_01E0, dC ^ 256'h4, 1, 0, 0);
        tag = "R11"; cmd(5'b11100);     // clear both + suspend
        cmd(5'b00001);

        tag = "R4";
        wr(32'h0000_0040, dB, 1);
        wr(32'h0000_0040, dB, 0);       // narrow
        rd(1, 32'h0000_0040, dB ^ 256'h1, 1, 0, 1);
        wr(32'h0000_0040, dB, 1);
        wr(32'h0000_0044, dB, 1);       // misaligned
        rd(0, 32'h0000_0040, dB ^ 256'h1, 1, 0, 1);

        tag = "R5";
        wr(32'h0000_0040, dB, 1);
        cmd(5'b00010);
        rd(0, 32'h0000_0040, dB ^ 256'h1, 1, 0, 1);
        wr(32'h0000_0040, dB, 1);       // clears valid
        cmd(5'b00001);
        rd(0, 32'h0000_0040, dB ^ 256'h1, 1, 0, 1);

        tag = "R6";
        wr(32'h0000_0060, dB, 1);
        cmd(5'b00100);
        wr(32'h0000_0060, dB ^ 256'h10, 1);
        rd(1, 32'h0000_0060, dB ^ 256'h10, 1, 0, 1);
        cmd(5'b00001);
        rd(1, 32'h0000_0060, dB ^ 256'h10, 1, 0, 1);
        expect1("R6 injected fault seen", dma_err, 1'b1);

        tag = "R7";
        cmd(5'b10000);
        wr(32'h0000_0080, dA, 1);
        rd(0, 32'h0000_0080, dA ^ 256'h1, 1, 1, 1);
        rd(0, 32'h0000_0080, dA ^ 256'h1, 0, 0, 1);
        rd(0, 32'h0000_0084, dA ^ 256'h1, 1, 0, 1);
        expect1("R7 unchecked", stat[3], 1'b0);

        tag = "R11";
        rd(0, 32'h0000_0080, dA ^ 256'h1, 1, 0, 0);
        cmd_we = 1; cmd_bits = 5'b01000;
        rd(0, 32'h8000_01E0, dC ^ 256'h1, 1, 0, 0);
        expect1("R11 clear then record", fetch_err, 1'b1);
        cmd(5'b11000);
        cyc();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule